// File: doc/BRIEF.md
# Prescaled Interval Timer with Event Outputs

This block is a down-counting interval timer for a performance-monitoring unit. Software writes an initial value and a control word through a small register port. Setting the enable bit loads the count from the initial value. The count then decreases at one of eight power-of-two fractions of the core clock. The timer ends an interval on a prescaled step taken while the count is already zero.

In one-shot mode the end of an interval stops the timer and raises a sticky done flag. In repetitive mode the timer reloads after a fixed gap, and nothing is reported. An external disable input forces the timer out of repetitive mode.

While the timer is enabled and the count is nonzero, it produces a gating window. That window can drive a local count-enable for neighbouring event counters, or one of four active-low event pins. The done flag can also be routed to one of those pins.

Top module: `intv_timer`

## Requirements
- R1: The count decreases once every 2^P clocks, where P is the 3-bit prescale field (control bits 10:8). The prescale phase restarts on every load, so the first decrement comes a full period after the load.
- R2: A control write (address 0) with bit 0 set while the timer is stopped starts an interval. It loads the count from the initial-value register (address 1) and clears the done flag.
- R3: An interval ends on the prescaled step taken while the count is zero. With initial value N, the window (count nonzero) therefore lasts N·2^P clocks, and the interval ends (N+1)·2^P clocks after the start.
- R4: In one-shot mode (control bit 7 clear), the end of an interval clears the enable bit and sets the done flag (control bit 6) on the same edge.
- R5: In repetitive mode, the end of an interval leaves the enable bit set and the done flag unchanged. The count reloads exactly 12 clocks after the ending edge.
- R6: A high ext_disable clears the repetitive-mode bit on the next edge, and it overrides a write in the same cycle. If that bit is clear when a reload gap expires, the timer stops and sets done, as in one-shot mode.
- R7: The done flag is sticky. A control write with bit 6 at 0 clears it. A write with bit 6 at 1 leaves it as it was, and software can never set it.
- R8: The done flag drives event pin S, where S is control bits 5:4, only while the status-output enable (control bit 15) is set. Otherwise no pin shows it.
- R9: Control bits 3:1 select the window output. Code 000 drives local_cnt_en. Codes 100 to 111 drive event pins 0 to 3. Codes 001 to 011 drive nothing.
- R10: Event pins are active low. Each pin is low when either of its sources is active, and high otherwise.
- R11: Reads at address 0 return the control word: bit 15 status enable, bits 10:8 prescale, bit 7 repetitive mode, bit 6 done, bits 5:4 status pin, bits 3:1 window code, bit 0 live enable. Bits 14:11 read 0. Reads at address 1 return the initial value.
- R12: A control write freezes the prescaler, the count and the gap counter for that cycle. Writing 0 to bit 0 stops the timer, cancels any pending reload and leaves done unchanged.
- R13: After reset all state is zero, every event pin is high and local_cnt_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control word, 1 initial value |
| wr_data | input | 16 | Write data |
| rd_addr | input | 1 | Read select: 0 control word, 1 initial value |
| rd_data | output | 16 | Read data, combinational |
| ext_disable | input | 1 | External request to leave repetitive mode |
| ev_n | output | 4 | Active-low event pins |
| local_cnt_en | output | 1 | Count enable for local event counters |

## Verification
Most wrong state in this block shows at the ports within one prescale period. A misplaced count or prescale phase moves the falling edge of the window on local_cnt_en or on an event pin, and the mismatch appears on the same cycle. A wrong gap length shows up on the first reload, 12 clocks after the interval ends. A wrong done flag or enable bit shows at once in the control-word readback, and on the routed status pin whenever the status output is enabled.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;
  localparam int DATA_W = 16;
  localparam int PS_W   = 3;
  localparam int PRE_W  = (1 << PS_W) - 1;
  localparam int PIN_N  = 4;
  localparam int SEL_W  = $clog2(PIN_N);
  localparam int CODE_W = 3;

  // control word bit positions (software-visible encoding)
  localparam int B_EN   = 0;
  localparam int B_CODE = 1;
  localparam int B_STAT = 4;
  localparam int B_DONE = 6;
  localparam int B_REP  = 7;
  localparam int B_PS   = 8;
  localparam int B_OE   = 15;

  function automatic logic [PRE_W-1:0] div_minus1(input logic [PS_W-1:0] code);
    return PRE_W'((1 << code) - 1);
  endfunction

  function automatic logic [PIN_N-1:0] pin_onehot(input logic [SEL_W-1:0] sel);
    return PIN_N'(1) << sel;
  endfunction
endpackage

// File: rtl/intv_regs.sv
module intv_regs
  import intv_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_init,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  init_q,
  output logic [CODE_W-1:0] code_q,
  output logic [SEL_W-1:0]  stat_sel_q,
  output logic              stat_oe_q,
  output logic [PS_W-1:0]   ps_q
);
  logic unused_bits;
  assign unused_bits = ^wr_data[B_OE-1:B_PS+PS_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q     <= '0;
      code_q     <= '0;
      stat_sel_q <= '0;
      stat_oe_q  <= 1'b0;
      ps_q       <= '0;
    end else begin
      if (wr_init) init_q <= wr_data[CNT_W-1:0];
      if (wr_ctrl) begin
        code_q     <= wr_data[B_CODE +: CODE_W];
        stat_sel_q <= wr_data[B_STAT +: SEL_W];
        stat_oe_q  <= wr_data[B_OE];
        ps_q       <= wr_data[B_PS +: PS_W];
      end
    end
  end
endmodule

// File: rtl/intv_prescaler.sv
module intv_prescaler
  import intv_timer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] ps,
  input  logic            advance,
  input  logic            clear,
  output logic            tick
);
  logic [PRE_W-1:0] phase_q;

  assign tick = advance && (phase_q >= div_minus1(ps));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (clear)   phase_q <= '0;
    else if (advance) phase_q <= tick ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/intv_engine.sv
module intv_engine
  import intv_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int GAP   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_disable,
  input  logic [CNT_W-1:0]  init_q,
  input  logic              tick,
  output logic              run,
  output logic              load,
  output logic              en_q,
  output logic              rep_q,
  output logic              done_q,
  output logic              win,
  output logic              complete_once,
  output logic              complete_rep,
  output logic              gap_reload
);
  localparam int GAP_W = $clog2(GAP + 1);

  logic [CNT_W-1:0] count_q;
  logic             in_gap_q;
  logic [GAP_W-1:0] gap_q;
  logic             start, complete, gap_end, gap_finish, stop;

  assign start         = wr_ctrl && wr_data[B_EN] && !en_q;
  assign run           = en_q && !in_gap_q && !wr_ctrl;
  assign complete      = run && tick && (count_q == '0);
  assign complete_once = complete && !rep_q;
  assign complete_rep  = complete && rep_q;
  assign gap_end       = en_q && in_gap_q && !wr_ctrl && (gap_q == GAP_W'(1));
  assign gap_reload    = gap_end && rep_q;
  assign gap_finish    = gap_end && !rep_q;
  assign stop          = complete_once || gap_finish;
  assign load          = start || gap_reload;
  assign win           = en_q && (count_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      rep_q    <= 1'b0;
      done_q   <= 1'b0;
      count_q  <= '0;
      in_gap_q <= 1'b0;
      gap_q    <= '0;
    end else begin
      if (wr_ctrl)   en_q <= wr_data[B_EN];
      else if (stop) en_q <= 1'b0;

      if (ext_disable)  rep_q <= 1'b0;
      else if (wr_ctrl) rep_q <= wr_data[B_REP];

      if (start)        done_q <= 1'b0;
      else if (wr_ctrl) done_q <= done_q && wr_data[B_DONE];
      else if (stop)    done_q <= 1'b1;

      if (load)                             count_q <= init_q;
      else if (run && tick && count_q != '0) count_q <= count_q - 1'b1;

      if (wr_ctrl && !wr_data[B_EN])       in_gap_q <= 1'b0;
      else if (complete_rep)               in_gap_q <= 1'b1;
      else if (gap_reload || gap_finish)   in_gap_q <= 1'b0;

      if (complete_rep)                    gap_q <= GAP_W'(GAP);
      else if (en_q && in_gap_q && !wr_ctrl) gap_q <= gap_q - 1'b1;
    end
  end
endmodule

// File: rtl/intv_pin_mux.sv
module intv_pin_mux
  import intv_timer_pkg::*;
(
  input  logic              win,
  input  logic              done,
  input  logic [CODE_W-1:0] code,
  input  logic [SEL_W-1:0]  stat_sel,
  input  logic              stat_oe,
  output logic [PIN_N-1:0]  ev_n,
  output logic              local_cnt_en
);
  logic [PIN_N-1:0] win_hit, stat_hit;

  assign win_hit  = (win && code[CODE_W-1]) ? pin_onehot(code[SEL_W-1:0]) : '0;
  assign stat_hit = (stat_oe && done) ? pin_onehot(stat_sel) : '0;
  assign local_cnt_en = win && (code == '0);

  for (genvar p = 0; p < PIN_N; p++) begin : g_pin
    assign ev_n[p] = !(win_hit[p] || stat_hit[p]);
  end
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_timer_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RELOAD_GAP = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_disable,
  output logic [PIN_N-1:0]  ev_n,
  output logic              local_cnt_en
);
  logic              wr_ctrl, wr_init;
  logic [CNT_W-1:0]  init_q;
  logic [CODE_W-1:0] code_q;
  logic [SEL_W-1:0]  stat_sel_q;
  logic              stat_oe_q;
  logic [PS_W-1:0]   ps_q;
  logic              tick, run, load;
  logic              en_q, rep_q, done_q, win;
  logic              complete_once, complete_rep, gap_reload;

  assign wr_ctrl = wr_en && !wr_addr;
  assign wr_init = wr_en && wr_addr;

  intv_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_init(wr_init),
    .wr_data(wr_data), .init_q(init_q), .code_q(code_q),
    .stat_sel_q(stat_sel_q), .stat_oe_q(stat_oe_q), .ps_q(ps_q)
  );

  intv_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .ps(ps_q), .advance(run), .clear(load),
    .tick(tick)
  );

  intv_engine #(.CNT_W(CNT_W), .GAP(RELOAD_GAP)) u_eng (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .ext_disable(ext_disable), .init_q(init_q), .tick(tick), .run(run),
    .load(load), .en_q(en_q), .rep_q(rep_q), .done_q(done_q), .win(win),
    .complete_once(complete_once), .complete_rep(complete_rep),
    .gap_reload(gap_reload)
  );

  intv_pin_mux u_mux (
    .win(win), .done(done_q), .code(code_q), .stat_sel(stat_sel_q),
    .stat_oe(stat_oe_q), .ev_n(ev_n), .local_cnt_en(local_cnt_en)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr) begin
      rd_data = DATA_W'(init_q);
    end else begin
      rd_data[B_EN]             = en_q;
      rd_data[B_CODE +: CODE_W] = code_q;
      rd_data[B_STAT +: SEL_W]  = stat_sel_q;
      rd_data[B_DONE]           = done_q;
      rd_data[B_REP]            = rep_q;
      rd_data[B_PS +: PS_W]     = ps_q;
      rd_data[B_OE]             = stat_oe_q;
    end
  end
endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk
  import intv_timer_pkg::*;
#(
  parameter int GAP = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_ctrl,
  input logic              ext_disable,
  input logic              en_q,
  input logic              rep_q,
  input logic              done_q,
  input logic              win,
  input logic              complete_once,
  input logic              complete_rep,
  input logic              gap_reload,
  input logic [CODE_W-1:0] code_q,
  input logic              stat_oe_q,
  input logic [PIN_N-1:0]  ev_n,
  input logic              local_cnt_en
);
  localparam int AGE_W = $clog2(GAP + 2) + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  logic [AGE_W-1:0] gap_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap_age <= '0;
    else if (complete_rep)             gap_age <= AGE_W'(1);
    else if (gap_reload || !en_q)      gap_age <= '0;
    else if (gap_age != '0 && !wr_ctrl && gap_age != AGE_MAX)
      gap_age <= gap_age + 1'b1;
  end

  assert_no_done_in_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !$past(rep_q));
  assert_gap_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gap_reload |-> (gap_age == AGE_W'(GAP)));
  assert_ext_clears_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_disable |=> !rep_q);
  assert_oneshot_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    complete_once |=> (!en_q && done_q));
  assert_local_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    local_cnt_en |-> (en_q && win && code_q == '0));
  assert_pins_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_oe_q && !code_q[CODE_W-1]) |-> (ev_n == '1));
endmodule

bind intv_timer intv_timer_chk #(.GAP(RELOAD_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .ext_disable(ext_disable),
  .en_q(en_q), .rep_q(rep_q), .done_q(done_q), .win(win),
  .complete_once(complete_once), .complete_rep(complete_rep),
  .gap_reload(gap_reload), .code_q(code_q), .stat_oe_q(stat_oe_q),
  .ev_n(ev_n), .local_cnt_en(local_cnt_en)
);

// File: tb/intv_timer_bench.sv
`timescale 1ns/1ps
module intv_timer_bench;
  localparam int GAP = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0, ext_dis = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [3:0]  ev_n;
  logic        local_cnt_en;

  int checks = 0, errors = 0;

  // reference state
  bit       m_en, m_rep, m_done, m_gap, m_oe;
  int       m_cnt, m_gcnt, m_pre, m_init;
  bit [2:0] m_code, m_ps;
  bit [1:0] m_stat;

  always #2 clk = ~clk;

  intv_timer u_intv_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ext_disable(ext_dis), .ev_n(ev_n), .local_cnt_en(local_cnt_en)
  );

  function automatic bit m_win();
    return m_en && (m_cnt != 0);
  endfunction

  function automatic bit [3:0] exp_pins();
    bit [3:0] r = 4'hF;
    for (int p = 0; p < 4; p++) begin
      if ((m_win() && m_code[2] && m_code[1:0] == p) || (m_oe && m_done && m_stat == p))
        r[p] = 1'b0;
    end
    return r;
  endfunction

  function automatic bit [15:0] exp_rd(bit a);
    if (a) return 16'(m_init);
    return {m_oe, 4'b0, m_ps, m_rep, m_done, m_stat, m_code, m_en};
  endfunction

  function automatic bit [15:0] mk(bit en, bit [2:0] code, bit [1:0] st, bit dn,
                                   bit rp, bit [2:0] ps, bit oe);
    return {oe, 4'hF, ps, rp, dn, st, code, en};  // bits 14:11 written as ones
  endfunction

  task automatic model_reset();
    m_en = 0; m_rep = 0; m_done = 0; m_gap = 0; m_oe = 0;
    m_cnt = 0; m_gcnt = 0; m_pre = 0; m_init = 0;
    m_code = 0; m_ps = 0; m_stat = 0;
  endtask

  task automatic model_step();
    bit wc = wr_en && !wr_addr;
    bit wi = wr_en && wr_addr;
    bit start = wc && wr_data[0] && !m_en;
    bit run = m_en && !m_gap && !wc;
    bit tk = run && (m_pre >= (1 << m_ps) - 1);
    bit fin = tk && m_cnt == 0;
    bit gend = m_en && m_gap && !wc && m_gcnt == 1;
    bit stop = (fin && !m_rep) || (gend && !m_rep);
    bit reload = gend && m_rep;
    bit load = start || reload;
    bit n_en = wc ? wr_data[0] : (stop ? 1'b0 : m_en);
    bit n_rep = ext_dis ? 1'b0 : (wc ? wr_data[7] : m_rep);
    bit n_done = start ? 1'b0 : (wc ? (m_done && wr_data[6]) : (stop ? 1'b1 : m_done));
    int n_cnt = load ? m_init : ((tk && m_cnt != 0) ? m_cnt - 1 : m_cnt);
    int n_pre = load ? 0 : (run ? (tk ? 0 : m_pre + 1) : m_pre);
    bit n_gap = (wc && !wr_data[0]) ? 1'b0 : ((fin && m_rep) ? 1'b1 : ((gend) ? 1'b0 : m_gap));
    int n_gcnt = (fin && m_rep) ? GAP : ((m_en && m_gap && !wc) ? m_gcnt - 1 : m_gcnt);
    if (wi) m_init = int'(wr_data);
    if (wc) begin
      m_code = wr_data[3:1]; m_stat = wr_data[5:4]; m_ps = wr_data[10:8]; m_oe = wr_data[15];
    end
    m_en = n_en; m_rep = n_rep; m_done = n_done; m_cnt = n_cnt;
    m_pre = n_pre; m_gap = n_gap; m_gcnt = n_gcnt;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic compare_all();
    check("R10 event pins", 32'(ev_n), 32'(exp_pins()));
    check("R9 local enable", 32'(local_cnt_en), 32'(m_win() && m_code == 0));
    check("R11 readback", 32'(rd_data), 32'(exp_rd(rd_addr)));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(bit a, bit [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13: reset state
    check("R13 pins after reset", 32'(ev_n), 32'hF);
    check("R13 local after reset", 32'(local_cnt_en), 0);
    check("R13 ctrl after reset", 32'(rd_data), 0);

    // R11: init readback and reserved bits
    rd_addr = 1'b1;
    wr(1, 16'h0ABC);
    check("R11 init readback", 32'(rd_data), 32'h0ABC);
    rd_addr = 1'b0;
    wr(1, 16'd3);
    wr(0, mk(0, 3'b000, 0, 0, 0, 3'd2, 0));
    check("R11 reserved bits read zero", 32'(rd_data[14:11]), 0);

    // R1 R2 R3 R4: one-shot, divide by 4, init 3
    wr(0, mk(1, 3'b000, 0, 0, 0, 3'd2, 0));
    check("R2 done cleared on start", 32'(rd_data[6]), 0);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (local_cnt_en) n++;
      cyc();
    end
    check("R1 R3 window length 3*4", 32'(n), 12);
    check("R4 done set", 32'(rd_data[6]), 1);
    check("R4 enable cleared", 32'(rd_data[0]), 0);

    // R7: sticky done
    wr(0, mk(0, 3'b000, 0, 1, 0, 3'd0, 0));
    check("R7 write one keeps done", 32'(rd_data[6]), 1);
    // R8: status routed to pin 2 with output enable
    wr(0, mk(0, 3'b000, 2'd2, 1, 0, 3'd0, 1));
    check("R8 status on pin 2", 32'(ev_n), 32'hB);
    wr(0, mk(0, 3'b000, 2'd2, 1, 0, 3'd0, 0));
    check("R8 no pin without enable", 32'(ev_n), 32'hF);
    wr(0, mk(0, 3'b000, 0, 0, 0, 3'd0, 0));
    check("R7 write zero clears done", 32'(rd_data[6]), 0);

    // R5: repetitive, init 1, divide 1, window on pin 0
    wr(1, 16'd1);
    wr(0, mk(1, 3'b100, 0, 0, 1, 3'd0, 0));
    n = 0;
    for (int i = 0; i < 42; i++) begin
      if (!ev_n[0]) n++;
      cyc();
    end
    check("R5 window once per 14 clocks", 32'(n), 3);
    check("R5 no done in repeat", 32'(rd_data[6]), 0);
    check("R5 enable kept", 32'(rd_data[0]), 1);

    // R6: external disable ends repetition
    ext_dis = 1'b1;
    cyc();
    ext_dis = 1'b0;
    check("R6 repeat bit cleared", 32'(rd_data[7]), 0);
    idle(20);
    check("R6 stops with done", 32'(rd_data[6]), 1);
    check("R6 enable cleared", 32'(rd_data[0]), 0);

    // R9: reserved code gives no output
    wr(1, 16'd5);
    wr(0, mk(1, 3'b010, 0, 0, 0, 3'd0, 0));
    check("R9 reserved code local", 32'(local_cnt_en), 0);
    check("R9 reserved code pins", 32'(ev_n), 32'hF);
    idle(10);
    // R10: window on pin 1 active low, others high
    wr(0, mk(1, 3'b101, 2'd1, 0, 0, 3'd1, 1));
    check("R10 pin 1 low only", 32'(ev_n), 32'hD);
    idle(15);
    check("R10 status on pin 1 after end", 32'(ev_n), 32'hD);

    // R12: software stop mid-interval
    wr(1, 16'd20);
    wr(0, mk(1, 3'b000, 0, 0, 0, 3'd0, 0));
    idle(4);
    wr(0, mk(0, 3'b000, 0, 0, 0, 3'd0, 0));
    check("R12 stop drops window", 32'(local_cnt_en), 0);
    idle(30);
    check("R12 stop leaves done clear", 32'(rd_data[6]), 0);

    // mixed random phase against the reference model
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 99);
      rd_addr = ($urandom_range(0, 3) == 0);
      ext_dis = ($urandom_range(0, 49) == 0);
      if (r < 3) begin
        wr(1, 16'($urandom_range(0, 6)));
      end else if (r < 7) begin
        bit [15:0] d = 16'($urandom);
        d[10] = 1'b0;
        d[0] = ($urandom_range(0, 3) != 0);
        wr(0, d);
      end else begin
        cyc();
      end
    end
    ext_dis = 1'b0;
    rd_addr = 1'b0;
    idle(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule